// File: doc/BRIEF.md
# PC-relative byte load unit

This unit runs a single load-byte instruction whose address is taken relative to the program counter. The instruction can arrive in one of two forms, and a select input tells the unit which one it has. The wide form is one 32-bit word. The compact form is two 16-bit halfwords packed into the same 32-bit input, with the first halfword in bits 31:16. The unit also takes the architectural PC read value and a condition-pass flag from the surrounding pipeline. When `start` is seen, the unit sorts the instruction into one of five outcomes: executed, undefined, handed to the unprivileged-load sibling, handed to the preload sibling, or condition failed. Only an executed instruction touches memory.

For an executed instruction, the unit clears the two low bits of the PC to form the base. It adds or subtracts the zero-extended 12-bit immediate, using a direction bit to choose, and the result wraps modulo 2^32. It then issues a one-byte read over a request/ready handshake and waits for a response strobe. The returned byte is zero-extended to 32 bits and presented on a one-cycle register-write port. Write-back to a base register never happens. Every other outcome finishes one cycle after `start` with a status code and no memory or register activity.

The sequencer has four states:
- `S_IDLE` moves to `S_REQ` on `start` when the outcome is executed. Any other outcome stays in `S_IDLE` and pulses `done`.
- `S_REQ` drives the request and moves to `S_WAIT_RSP` when `mem_ready` is sampled.
- `S_WAIT_RSP` moves to `S_WRITE` when `mem_rsp_valid` is sampled.
- `S_WRITE` strobes the write port and returns to `S_IDLE`.

Top module: `pcbyte_load_unit`

## Requirements
- R1: In the wide form, the unit executes the instruction (status 0) when all of these hold: the condition field bits 31:28 is not 1111, bits 27:25 are 010, bit 22 is 1, bit 20 is 1, bits 19:16 are 1111, P (bit 24) is 1, W (bit 21) is 0, the condition passes, and the destination in bits 15:12 is not 15. In the compact form, the unit executes when bits 31:24 are F8h, bits 22:20 are 001, bits 19:16 are 1111, the condition passes, and the destination is not 15. In both forms, the destination index (bits 15:12) appears on `rd_idx` with the write strobe.
- R2: In the wide form with valid fixed bits, P=0 together with W=1 completes with status 2 (unprivileged-load redirect) and no memory request.
- R3: In the wide form, status 1 (undefined) results from any of these: wrong fixed bits, a condition field of 1111, P=0 with W=0, P=1 with W=1, or a destination of 15.
- R4: In the compact form with valid fixed bits, a destination of 1111 completes with status 3 (preload redirect) and no memory request.
- R5: In the compact form, wrong fixed bits in the first halfword complete with status 1.
- R6: The read address is the PC with bits 1:0 cleared, plus the zero-extended imm12 (bits 11:0) when U (bit 23) is 1, or minus it when U is 0. The result wraps modulo 2^32, and U=0 with a zero immediate is legal.
- R7: The returned byte is written zero-extended to 32 bits. `rd_we` and `done` are high together for exactly one cycle, with status 0.
- R8: A failed condition gives status 4 with no memory request and no register write. Sorting by encoding comes first, so an undefined or redirected instruction reports its own code whatever the condition flag is.
- R9: The request stays high with a stable address until `mem_ready` is sampled. A response strobe is taken only after the request has been accepted. The number of cycles from `start` to `done` depends only on the handshake delays and never on the data value.
- R10: `busy` goes high the cycle after an executing `start` and falls after the write cycle. A non-executing outcome raises `done` the cycle after `start` while `busy` stays low.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction, sampled in idle |
| enc_wide | input | 1 | 1 = wide 32-bit form, 0 = compact halfword pair |
| instr | input | 32 | Instruction bits; compact form uses bits 31:16 for the first halfword |
| pc_val | input | 32 | Architectural PC read value |
| cond_pass | input | 1 | Condition check result from the pipeline |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte address, valid while `mem_req` is high |
| mem_ready | input | 1 | Request accepted in this cycle |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 8 | Returned byte |
| rd_we | output | 1 | Destination register write strobe |
| rd_idx | output | 4 | Destination register index, valid with `rd_we` |
| rd_data | output | 32 | Zero-extended byte, valid with `rd_we` |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Outcome code, valid with `done` |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- **Address wrap.** A subtraction below address zero and an addition past the top of the space check the wrap. A unit that forgot to clear the PC's low bits, or that ignored the direction bit, would put the wrong address on `mem_addr`.
- **Zero offset with subtraction.** The legal subtract-zero case is included. A design that flagged it as undefined would report the wrong status.
- **Indexing combinations in the wide form.** All four combinations of the indexing bits are applied, along with a destination of 15. A design that confused the redirect with the reject, or that still issued a read, would give a wrong status or an unexpected request.
- **Compact preload case.** This case is driven with the condition both failing and passing. A unit that let the condition code override the redirect would answer 4 instead of 3.
- **Stray responses and `start` held high.** Response strobes are sent before the request is accepted, and `start` is held high while the unit is busy. A unit that accepted either would load junk or begin a second access.
- **Data-independent timing.** Latencies for bytes with and without the top bit set are compared. This catches both a sign-extending write path and data-dependent timing.

// File: rtl/pcbl_pkg.sv
package pcbl_pkg;

    typedef enum logic [2:0] {
        OC_EXEC       = 3'd0,
        OC_UNDEF      = 3'd1,
        OC_TO_UNPRIV  = 3'd2,
        OC_TO_PRELOAD = 3'd3,
        OC_COND_FAIL  = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_REQ      = 2'd1,
        S_WAIT_RSP = 2'd2,
        S_WRITE    = 2'd3
    } seq_e;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned IMM_W   = 12;
    localparam int unsigned REG_W   = 4;

    typedef struct packed {
        outcome_e           outcome;
        logic               add;
        logic [REG_W-1:0]   rt;
        logic [IMM_W-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/pcbl_decode.sv
module pcbl_decode
    import pcbl_pkg::*;
(
    input  logic               enc_wide,
    input  logic [INSTR_W-1:0] instr,
    input  logic               cond_pass,
    output dec_t               dec
);

    localparam logic [REG_W-1:0] PC_REG = '1;

    logic     wide_fixed_ok;
    logic     pair_fixed_ok;
    logic     p_bit;
    logic     w_bit;
    outcome_e wide_cls;
    outcome_e pair_cls;
    outcome_e enc_cls;

    // Fixed-pattern match for each form
    always_comb begin
        wide_fixed_ok = (instr[31:28] != 4'hF) && (instr[27:25] == 3'b010) &&
                        instr[22] && instr[20] && (instr[19:16] == 4'hF);
        pair_fixed_ok = (instr[31:24] == 8'hF8) && (instr[22:20] == 3'b001) &&
                        (instr[19:16] == 4'hF);
        p_bit = instr[24];
        w_bit = instr[21];
    end

    // Wide form: redirect before generic write-back reject
    always_comb begin
        if (!wide_fixed_ok) begin
            wide_cls = OC_UNDEF;
        end else if (!p_bit && w_bit) begin
            wide_cls = OC_TO_UNPRIV;
        end else if (!p_bit || w_bit) begin
            wide_cls = OC_UNDEF;
        end else if (instr[15:12] == PC_REG) begin
            wide_cls = OC_UNDEF;
        end else begin
            wide_cls = OC_EXEC;
        end
    end

    // Compact form: destination 15 goes to the preload sibling
    always_comb begin
        if (!pair_fixed_ok) begin
            pair_cls = OC_UNDEF;
        end else if (instr[15:12] == PC_REG) begin
            pair_cls = OC_TO_PRELOAD;
        end else begin
            pair_cls = OC_EXEC;
        end
    end

    always_comb begin
        enc_cls = enc_wide ? wide_cls : pair_cls;
        dec.outcome = enc_cls;
        if (enc_cls == OC_EXEC && !cond_pass) begin
            dec.outcome = OC_COND_FAIL;
        end
        // U, Rt and imm12 share bit positions in both forms
        dec.add = instr[23];
        dec.rt  = instr[15:12];
        dec.imm = instr[11:0];
    end

    always_comb begin
        if (dec.outcome == OC_TO_PRELOAD) begin
            assert (!enc_wide)
                else $error("AST_PRELOAD_ONLY_COMPACT failed"); // R4
        end
    end

endmodule

// File: rtl/pcbl_addr.sv
module pcbl_addr #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IMM_W      = 12,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              add,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    generate
        if (ALIGN_BITS == 0) begin : g_no_align
            assign base = pc_val;
        end else begin : g_align
            assign base = pc_val & ~LOW_MASK;
        end
    endgenerate

    assign offset = {{(ADDR_W-IMM_W){1'b0}}, imm};

    // Modulo 2^ADDR_W arithmetic by truncation
    always_comb begin
        if (add) begin
            addr = base + offset;
        end else begin
            addr = base - offset;
        end
    end

endmodule

// File: rtl/pcbl_seq.sv
module pcbl_seq
    import pcbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              rd_we,
    output logic [REG_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [2:0]        status
);

    localparam int unsigned PAD_W = DATA_W - BYTE_W;

    seq_e              state_q;
    seq_e              state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  rt_q;
    outcome_e          code_q;
    logic              short_q;
    logic [BYTE_W-1:0] byte_q;
    logic              launch;

    assign launch = (state_q == S_IDLE) && start;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (launch && dec.outcome == OC_EXEC) begin
                    state_d = S_REQ;
                end
            end
            S_REQ: begin
                if (mem_ready) begin
                    state_d = S_WAIT_RSP;
                end
            end
            S_WAIT_RSP: begin
                if (rsp_valid) begin
                    state_d = S_WRITE;
                end
            end
            S_WRITE: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured operands and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rt_q    <= '0;
            code_q  <= OC_EXEC;
            short_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            short_q <= 1'b0;
            if (launch) begin
                addr_q  <= addr_in;
                rt_q    <= dec.rt;
                code_q  <= dec.outcome;
                short_q <= (dec.outcome != OC_EXEC);
            end
            if (state_q == S_WAIT_RSP && rsp_valid) begin
                byte_q <= rsp_data;
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        mem_req  = (state_q == S_REQ);
        mem_addr = addr_q;
        rd_we    = (state_q == S_WRITE);
        rd_idx   = rt_q;
        rd_data  = {{PAD_W{1'b0}}, byte_q};
        done     = rd_we || short_q;
        status   = code_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R9

    AST_SHORT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done && (status != 3'd0) |-> !busy && !mem_req && !rd_we); // R8

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |=> !rd_we && !busy); // R7

    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> $past(rsp_valid) && (rd_data == {{PAD_W{1'b0}}, $past(rsp_data)})); // R7

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req); // R10

    AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !rd_we); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rd_we |=> busy); // R11

endmodule

// File: rtl/pcbyte_load_unit.sv
module pcbyte_load_unit
    import pcbl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enc_wide,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic              cond_pass,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rsp_valid,
    input  logic [BYTE_W-1:0] mem_rsp_data,
    output logic              rd_we,
    output logic [3:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [2:0]        status
);

    dec_t              dec;
    logic [ADDR_W-1:0] ea;

    pcbl_decode u_decode (
        .enc_wide  (enc_wide),
        .instr     (instr),
        .cond_pass (cond_pass),
        .dec       (dec)
    );

    pcbl_addr #(
        .ADDR_W     (ADDR_W),
        .IMM_W      (IMM_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_addr (
        .pc_val (pc_val),
        .imm    (dec.imm),
        .add    (dec.add),
        .addr   (ea)
    );

    pcbl_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec       (dec),
        .addr_in   (ea),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ready (mem_ready),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .rd_we     (rd_we),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done),
        .status    (status)
    );

endmodule

// File: tb/pcbyte_load_unit_test.sv
`timescale 1ns/1ps
module pcbyte_load_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        enc_wide = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] pc_val = '0;
    logic        cond_pass = 1'b1;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        rd_we;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        busy;
    logic        done;
    logic [2:0]  status;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    pcbyte_load_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .enc_wide(enc_wide),
        .instr(instr), .pc_val(pc_val), .cond_pass(cond_pass),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Requirement-level classification
    function automatic int classify(input bit wide, input logic [31:0] w, input bit cp);
        int r;
        r = 0;
        if (wide) begin
            if (w[31:28] == 4'hF || w[27:25] != 3'b010 || !w[22] || !w[20] || w[19:16] != 4'hF) r = 1;
            else if (w[24] == 1'b0 && w[21] == 1'b1) r = 2;
            else if (w[24] == 1'b0 || w[21] == 1'b1) r = 1;
            else if (w[15:12] == 4'd15) r = 1;
        end else begin
            if (w[31:24] != 8'hF8 || w[22:20] != 3'b001 || w[19:16] != 4'hF) r = 1;
            else if (w[15:12] == 4'd15) r = 3;
        end
        if (r == 0 && !cp) r = 4;
        return r;
    endfunction

    function automatic logic [31:0] expect_addr(input logic [31:0] pc, input logic [11:0] imm, input bit u);
        longint b;
        longint a;
        b = longint'(pc) & 64'hFFFF_FFFC;
        a = u ? b + longint'(imm) : b - longint'(imm) + 64'h1_0000_0000;
        return a[31:0];
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return (a[7:0] ^ a[15:8] ^ 8'h3C) + a[23:16] + {a[1:0], 6'b0};
    endfunction

    function automatic logic [31:0] wide_word(input logic [3:0] c, input bit p, input bit u,
                                              input bit w, input logic [3:0] rt, input logic [11:0] imm);
        return {c, 3'b010, p, u, 1'b1, w, 1'b1, 4'hF, rt, imm};
    endfunction

    function automatic logic [31:0] pair_word(input bit u, input logic [3:0] rt, input logic [11:0] imm);
        return {8'hF8, u, 3'b001, 4'hF, rt, imm};
    endfunction

    // Behavioural reference model
    int          m_ph = 0;
    bit          m_short = 0;
    int          m_stat = 0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_rt = '0;
    logic [7:0]  m_byte = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_short = 0; m_stat = 0;
        end else begin
            m_short = 0;
            case (m_ph)
                0: if (start) begin
                    m_stat = classify(enc_wide, instr, cond_pass);
                    if (m_stat == 0) begin
                        m_ph = 1;
                        m_addr = expect_addr(pc_val, instr[11:0], instr[23]);
                        m_rt = instr[15:12];
                    end else m_short = 1;
                end
                1: if (mem_ready) m_ph = 2;
                2: if (mem_rsp_valid) begin m_byte = mem_rsp_data; m_ph = 3; end
                3: m_ph = 0;
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        chk(busy == (m_ph != 0), "R10", "busy", {31'b0, busy}, {31'b0, m_ph != 0});
        chk(mem_req == (m_ph == 1), "R9", "mem_req", {31'b0, mem_req}, {31'b0, m_ph == 1});
        if (m_ph == 1) chk(mem_addr == m_addr, "R6", "mem_addr", mem_addr, m_addr);
        chk(rd_we == (m_ph == 3), "R7", "rd_we", {31'b0, rd_we}, {31'b0, m_ph == 3});
        chk(done == (m_ph == 3 || m_short), "R10", "done", {31'b0, done}, {31'b0, (m_ph == 3 || m_short)});
        if (m_ph == 3) begin
            chk(rd_data == {24'b0, m_byte}, "R7", "rd_data", rd_data, {24'b0, m_byte});
            chk(rd_idx == m_rt, "R1", "rd_idx", {28'b0, rd_idx}, {28'b0, m_rt});
        end
        if (m_ph == 3 || m_short)
            chk(status == 3'(m_stat), cur_tag, "status", {29'b0, status}, 32'(m_stat));
    end

    // Memory responder
    int ready_dly = 0;
    int rsp_dly = 0;
    bit spur_en = 0;
    int rp = 0;
    int rcnt = 0;
    logic [31:0] paddr = '0;

    always @(posedge clk) begin
        #3;
        mem_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = 8'h00;
        if (!rst_n) begin
            rp = 0; rcnt = 0;
        end else begin
            case (rp)
                0: if (mem_req) begin
                    if (rcnt >= ready_dly) begin
                        mem_ready = 1'b1; paddr = mem_addr; rp = 1; rcnt = 0;
                    end else begin
                        rcnt++;
                        if (spur_en) begin mem_rsp_valid = 1'b1; mem_rsp_data = 8'hA5; end
                    end
                end else rcnt = 0;
                1: begin rp = 2; rcnt = 0;
                    if (rsp_dly == 0) begin
                        mem_rsp_valid = 1'b1; mem_rsp_data = byte_at(paddr); rp = 3;
                    end
                end
                2: if (rcnt + 1 >= rsp_dly) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = byte_at(paddr); rp = 3;
                end else rcnt++;
                default: rp = 0;
            endcase
        end
    end

    task automatic run_op(input bit wide, input logic [31:0] w, input logic [31:0] pc, input bit cp,
                          input int rd, input int sd, input int hold, input string tag,
                          input int exp_stat, output int lat);
        bit seen;
        ready_dly = rd; rsp_dly = sd; cur_tag = tag;
        @(posedge clk); #3;
        enc_wide = wide; instr = w; pc_val = pc; cond_pass = cp; start = 1'b1;
        @(posedge clk); #3;
        lat = 1;
        for (int k = 0; k < hold; k++) begin
            instr = ~w; pc_val = ~pc;
            @(posedge clk); #3;
            lat++;
        end
        start = 1'b0;
        seen = (done === 1'b1);
        while (!seen && lat < 300) begin
            @(posedge clk); #3;
            lat++;
            seen = (done === 1'b1);
        end
        chk(seen && status == 3'(exp_stat), tag, "completion status", {29'b0, status}, 32'(exp_stat));
        if (rp == 3) rp = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int l0;
        int l1;
        logic [31:0] w;
        repeat (3) @(posedge clk);
        #3;
        chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10", "reset state",
            {29'b0, busy, done, mem_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 / R6: wide add, unaligned PC
        run_op(1, wide_word(4'hE, 1, 1, 0, 4'd5, 12'h123), 32'h0000_1003, 1, 0, 0, 0, "R1", 0, l0);
        // R6: subtract zero
        run_op(1, wide_word(4'h0, 1, 0, 0, 4'd2, 12'h000), 32'h0000_2006, 1, 1, 1, 0, "R6", 0, l0);
        // R6: subtract below zero wraps
        run_op(1, wide_word(4'h1, 1, 0, 0, 4'd7, 12'h010), 32'h0000_0002, 1, 0, 2, 0, "R6", 0, l0);
        // R6: add past top wraps
        run_op(1, wide_word(4'hA, 1, 1, 0, 4'd9, 12'hFFF), 32'hFFFF_FFFE, 1, 2, 0, 0, "R6", 0, l0);
        // R2: P=0 W=1
        run_op(1, wide_word(4'hE, 0, 1, 1, 4'd3, 12'h044), 32'h100, 1, 0, 0, 0, "R2", 2, l0);
        run_op(1, wide_word(4'hE, 0, 0, 1, 4'd3, 12'h044), 32'h100, 0, 0, 0, 0, "R2", 2, l0);
        // R3: undefined cases
        run_op(1, wide_word(4'hE, 0, 1, 0, 4'd3, 12'h044), 32'h100, 1, 0, 0, 0, "R3", 1, l0);
        run_op(1, wide_word(4'hE, 1, 1, 1, 4'd3, 12'h044), 32'h100, 1, 0, 0, 0, "R3", 1, l0);
        run_op(1, wide_word(4'hE, 1, 1, 0, 4'd15, 12'h044), 32'h100, 1, 0, 0, 0, "R3", 1, l0);
        run_op(1, wide_word(4'hF, 1, 1, 0, 4'd3, 12'h044), 32'h100, 1, 0, 0, 0, "R3", 1, l0);
        w = wide_word(4'hE, 1, 1, 0, 4'd3, 12'h044); w[22] = 1'b0;
        run_op(1, w, 32'h100, 1, 0, 0, 0, "R3", 1, l0);
        // R1 compact form
        run_op(0, pair_word(1, 4'd13, 12'hFFF), 32'h0040_0001, 1, 3, 2, 0, "R1", 0, l0);
        run_op(0, pair_word(0, 4'd0, 12'h801), 32'h0040_0800, 1, 1, 3, 0, "R1", 0, l0);
        // R4: preload redirect, condition either way
        run_op(0, pair_word(1, 4'd15, 12'h020), 32'h300, 1, 0, 0, 0, "R4", 3, l0);
        run_op(0, pair_word(0, 4'd15, 12'h020), 32'h300, 0, 0, 0, 0, "R4", 3, l0);
        // R5: bad first halfword
        w = pair_word(1, 4'd4, 12'h020); w[21] = 1'b1;
        run_op(0, w, 32'h300, 1, 0, 0, 0, "R5", 1, l0);
        w = pair_word(1, 4'd4, 12'h020); w[24] = 1'b1;
        run_op(0, w, 32'h300, 1, 0, 0, 0, "R5", 1, l0);
        // R8: condition failed
        run_op(1, wide_word(4'hE, 1, 1, 0, 4'd5, 12'h010), 32'h500, 0, 0, 0, 0, "R8", 4, l0);
        run_op(0, pair_word(1, 4'd6, 12'h010), 32'h500, 0, 0, 0, 0, "R8", 4, l0);
        // R11: start held high while busy
        run_op(1, wide_word(4'hE, 1, 1, 0, 4'd8, 12'h0AB), 32'h0000_7000, 1, 4, 1, 3, "R11", 0, l0);
        // R9: stray responses before acceptance
        spur_en = 1;
        run_op(0, pair_word(1, 4'd1, 12'h00C), 32'h0000_9000, 1, 4, 2, 0, "R9", 0, l0);
        spur_en = 0;
        // R9 / R7: latency independent of data value (bytes with/without MSB)
        run_op(1, wide_word(4'hE, 1, 1, 0, 4'd2, 12'h0C0), 32'h0000_0000, 1, 2, 2, 0, "R7", 0, l0);
        run_op(1, wide_word(4'hE, 1, 1, 0, 4'd2, 12'h03C), 32'h0000_0000, 1, 2, 2, 0, "R7", 0, l1);
        chk(byte_at(32'h0C0) != byte_at(32'h03C), "R9", "distinct bytes", {24'b0, byte_at(32'h0C0)}, {24'b0, byte_at(32'h03C)});
        chk(l0 == l1, "R9", "latency", 32'(l1), 32'(l0));

        // Mixed sweep
        for (int i = 0; i < 60; i++) begin
            bit wd;
            bit cp;
            int es;
            wd = 1'($urandom);
            cp = ($urandom % 5) != 0;
            if (wd) w = wide_word(4'($urandom % 15), 1'($urandom % 4 != 0), 1'($urandom),
                                  1'($urandom % 4 == 0), 4'($urandom), 12'($urandom));
            else w = pair_word(1'($urandom), 4'($urandom), 12'($urandom));
            if ($urandom % 8 == 0) w[20 + ($urandom % 4)] = ~w[20 + ($urandom % 4)];
            es = classify(wd, w, cp);
            run_op(wd, w, $urandom, cp, $urandom % 4, $urandom % 4, 0, "R1", es, l0);
        end

        repeat (3) @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule